// File: doc/BRIEF.md
# Self-Test Observation Register Bank

This block is a bank of flip-flops placed at the edge of a combinational logic block so that the same storage can do four jobs: plain data capture, serial scan access, pseudo-random stimulus generation and response compaction. A 2-bit mode input picks the job. The bank is used in one of two ways. Feeding the logic under test, it runs in pattern mode and steps through a maximal-length pseudo-random sequence. Capturing that logic's outputs, it runs in signature mode and folds each cycle's response into a running syndrome.

A small run controller counts signature cycles. A one-cycle start pulse arms it, and it counts every edge at which the bank compacts. Once the programmed number of compactions has been reached, it compares the bank contents with an expected syndrome, raises done, and raises pass when the two agree. Both flags hold until the next start or reset.

Top module: `selftest_reg_bank`

## Requirements
- R1: A synchronous active-high reset loads the bank with the SEED parameter, which defaults to all ones. The same edge clears done and pass.
- R2: Mode 2'b00 (normal) loads every bit from the parallel input `din` at each clock edge.
- R3: Mode 2'b01 (scan) shifts the bank one place toward the MSB at each edge. Bit 0 takes `scan_in`, and `scan_out` always shows the current MSB.
- R4: Mode 2'b10 (pattern) shifts toward the MSB and loads bit 0 with the XOR of the state bits selected by the TAPS mask. At width 3 with taps 3'b101 and seed 111, the sequence is 111, 110, 101, 010, 100, 001, 011, and then 111 again.
- R5: In pattern mode a nonzero state never becomes zero. With a maximal tap mask the period is 2^WIDTH-1, which is 7 at width 3 and 255 at width 8 with taps 8'hB8.
- R6: Mode 2'b11 (signature) computes the pattern-mode next state and XORs each of its bits with the matching bit of `din`.
- R7: A start pulse clears done and pass. While mode is 2'b11, that start edge counts as compaction 1. When at least `sig_cycles` compactions have occurred, done rises on the following edge and stays high until the next start or reset. A `sig_cycles` value of 0 behaves as 1.
- R8: When done rises, pass is high exactly when the bank contents after the counted compactions equal `sig_expect`. Pass is never high while done is low.
- R9: A change on `mode` does not alter the bank until the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 normal, 01 scan, 10 pattern, 11 signature |
| din | input | WIDTH | Parallel data / response input |
| scan_in | input | 1 | Serial input into bit 0 |
| start | input | 1 | One-cycle pulse that arms a signature run |
| sig_cycles | input | CNT_W | Number of compactions in a run |
| sig_expect | input | WIDTH | Expected syndrome |
| q | output | WIDTH | Bank contents |
| scan_out | output | 1 | Serial output, the bank MSB |
| done | output | 1 | Signature run finished |
| pass | output | 1 | Syndrome matched, valid with done |

## Verification
The bench builds two copies of the bank. The first uses the default width of 3 with taps 3'b101 and seed 111. At that size every state can be listed, so the full seven-state pattern cycle, the scan path and hand-computable syndromes can all be checked exactly. The second uses width 8 with taps 8'hB8 and seed 8'h01. At that width the full 255-state period and the absence of the all-zero state can be checked in one pass, and a wrong tap decode or a wider feedback term would show up.

// File: rtl/stb_pkg.sv
package stb_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_SCAN    = 2'b01,
    MODE_PATTERN = 2'b10,
    MODE_SIGN    = 2'b11
  } stb_mode_e;
endpackage

// File: rtl/stb_feedback.sv
module stb_feedback #(
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] TAPS = 3'b101
) (
  input  logic [WIDTH-1:0] state,
  output logic             fb
);
  logic [WIDTH-1:0] picked;

  for (genvar i = 0; i < WIDTH; i++) begin : g_tap
    if (TAPS[i]) begin : g_on
      assign picked[i] = state[i];
    end else begin : g_off
      assign picked[i] = 1'b0;
    end
  end

  assign fb = ^picked;
endmodule

// File: rtl/stb_next_state.sv
module stb_next_state
  import stb_pkg::*;
#(
  parameter int WIDTH = 3
) (
  input  stb_mode_e        mode,
  input  logic [WIDTH-1:0] state,
  input  logic [WIDTH-1:0] din,
  input  logic             scan_in,
  input  logic             fb,
  output logic [WIDTH-1:0] nxt
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_scan;
    logic from_lfsr;
    if (i == 0) begin : g_lsb
      assign from_scan = scan_in;
      assign from_lfsr = fb;
    end else begin : g_upper
      assign from_scan = state[i-1];
      assign from_lfsr = state[i-1];
    end

    always_comb begin
      unique case (mode)
        MODE_NORMAL:  nxt[i] = din[i];
        MODE_SCAN:    nxt[i] = from_scan;
        MODE_PATTERN: nxt[i] = from_lfsr;
        default:      nxt[i] = from_lfsr ^ din[i];
      endcase
    end
  end
endmodule

// File: rtl/stb_run_ctrl.sv
module stb_run_ctrl #(
  parameter int WIDTH = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             compacting,
  input  logic [CNT_W-1:0] sig_cycles,
  input  logic [WIDTH-1:0] state,
  input  logic [WIDTH-1:0] sig_expect,
  output logic             done,
  output logic             pass
);
  logic             busy;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      count <= '0;
      done  <= 1'b0;
      pass  <= 1'b0;
    end else if (start) begin
      busy  <= 1'b1;
      count <= compacting ? CNT_W'(1) : '0;
      done  <= 1'b0;
      pass  <= 1'b0;
    end else if (busy) begin
      if (count >= sig_cycles && count != '0) begin
        busy <= 1'b0;
        done <= 1'b1;
        pass <= (state == sig_expect);
      end else if (compacting) begin
        count <= count + CNT_W'(1);
      end
    end
  end

  // R8: a pass flag only ever accompanies done
  p_pass_needs_done_r8: assert property (@(posedge clk) disable iff (rst)
    pass |-> done);

  // R7: done only rises at the end of an armed run
  p_done_from_run_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));

  // R7: done holds until a new start
  p_done_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
endmodule

// File: rtl/selftest_reg_bank.sv
module selftest_reg_bank
  import stb_pkg::*;
#(
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] TAPS = 3'b101,
  parameter logic [WIDTH-1:0] SEED = '1,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] din,
  input  logic             scan_in,
  input  logic             start,
  input  logic [CNT_W-1:0] sig_cycles,
  input  logic [WIDTH-1:0] sig_expect,
  output logic [WIDTH-1:0] q,
  output logic             scan_out,
  output logic             done,
  output logic             pass
);
  localparam int MSB = WIDTH - 1;

  stb_mode_e        mode_e;
  logic             fb;
  logic [WIDTH-1:0] nxt;

  assign mode_e = stb_mode_e'(mode);

  stb_feedback #(.WIDTH(WIDTH), .TAPS(TAPS)) u_fb (
    .state(q),
    .fb   (fb)
  );

  stb_next_state #(.WIDTH(WIDTH)) u_next (
    .mode   (mode_e),
    .state  (q),
    .din    (din),
    .scan_in(scan_in),
    .fb     (fb),
    .nxt    (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) q <= SEED;
    else     q <= nxt;
  end

  assign scan_out = q[MSB];

  stb_run_ctrl #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .compacting(mode_e == MODE_SIGN),
    .sig_cycles(sig_cycles),
    .state     (q),
    .sig_expect(sig_expect),
    .done      (done),
    .pass      (pass)
  );

  // R1: reset seeds the bank
  p_reset_seed_r1: assert property (@(posedge clk)
    rst |=> (q == SEED));

  // R2: normal mode captures the parallel input
  p_normal_load_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> (q == $past(din)));

  // R3: scan mode takes the serial input into bit 0
  p_scan_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |=> (q[0] == $past(scan_in)));

  // R5: the generator never falls into the all-zero state
  p_no_lockup_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && q != '0) |=> (q != '0));
endmodule

// File: tb/tb_selftest_reg_bank.sv
`timescale 1ns/1ps
module tb_selftest_reg_bank;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic [2:0] din = '0;
  logic       scan_in = 1'b0;
  logic       start = 1'b0;
  logic [7:0] sig_cycles = '0;
  logic [2:0] sig_expect = '0;
  logic [2:0] q;
  logic       scan_out, done, pass;

  logic       rst8 = 1'b1;
  logic [1:0] mode8 = 2'b00;
  logic [7:0] q8;
  logic       so8, done8, pass8;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  selftest_reg_bank dut (
    .clk(clk), .rst(rst), .mode(mode), .din(din), .scan_in(scan_in),
    .start(start), .sig_cycles(sig_cycles), .sig_expect(sig_expect),
    .q(q), .scan_out(scan_out), .done(done), .pass(pass)
  );

  selftest_reg_bank #(.WIDTH(8), .TAPS(8'hB8), .SEED(8'h01), .CNT_W(8)) dut_w8 (
    .clk(clk), .rst(rst8), .mode(mode8), .din(8'h00), .scan_in(1'b0),
    .start(1'b0), .sig_cycles(8'h00), .sig_expect(8'h00),
    .q(q8), .scan_out(so8), .done(done8), .pass(pass8)
  );

  function automatic logic [2:0] gen3(input logic [2:0] s);
    return {s[1:0], s[2] ^ s[0]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset;
    rst = 1'b1; start = 1'b0; mode = 2'b00;
    tick;
    rst = 1'b0;
  endtask

  task automatic t_reset;
    do_reset;
    check(q == 3'b111, "R1 seed", q, 3'b111);
    check(done == 0 && pass == 0, "R1 flags", {done, pass}, 0);
    check(scan_out == 1'b1, "R3 scan_out at seed", scan_out, 1);
  endtask

  task automatic t_normal;
    logic [2:0] v [3] = '{3'b101, 3'b000, 3'b011};
    mode = 2'b00;
    foreach (v[k]) begin
      din = v[k];
      tick;
      check(q == v[k], "R2 normal load", q, v[k]);
    end
  endtask

  task automatic t_scan;
    logic [2:0] m;
    logic [5:0] bits = 6'b011010;
    do_reset;
    m = 3'b111;
    mode = 2'b01;
    for (int k = 0; k < 6; k++) begin
      scan_in = bits[k];
      tick;
      m = {m[1:0], bits[k]};
      check(q == m, "R3 scan shift", q, m);
      check(scan_out == m[2], "R3 scan_out", scan_out, m[2]);
    end
  endtask

  task automatic t_pattern;
    logic [2:0] seq [7] = '{3'b110, 3'b101, 3'b010, 3'b100, 3'b001, 3'b011, 3'b111};
    do_reset;
    mode = 2'b10;
    foreach (seq[k]) begin
      tick;
      check(q == seq[k], "R4 pattern sequence", q, seq[k]);
      check(q != 3'b000, "R5 no zero state", q, 1);
    end
  endtask

  task automatic t_period8;
    int first_back = 0;
    bit saw_zero = 0;
    rst8 = 1'b1; tick; rst8 = 1'b0;
    mode8 = 2'b10;
    for (int k = 1; k <= 255; k++) begin
      tick;
      if (q8 == 8'h00) saw_zero = 1;
      if (q8 == 8'h01 && first_back == 0) first_back = k;
    end
    check(first_back == 255, "R5 width-8 period", first_back, 255);
    check(!saw_zero, "R5 width-8 no zero", saw_zero, 0);
  endtask

  task automatic t_signature;
    logic [2:0] m;
    do_reset;
    m = 3'b111;
    mode = 2'b11;
    for (int k = 0; k < 5; k++) begin
      din = 3'(k * 3 + 1);
      tick;
      m = gen3(m) ^ 3'(k * 3 + 1);
      check(q == m, "R6 signature step", q, m);
    end
  endtask

  task automatic t_mode_switch;
    do_reset;
    mode = 2'b00; din = 3'b010;
    tick;
    mode = 2'b10;
    #0.5;
    check(q == 3'b010, "R9 no change before edge", q, 3'b010);
    tick;
    check(q == 3'b100, "R9 new mode at edge", q, 3'b100);
  endtask

  task automatic sig_run(input int n, input bit good, input string tag);
    logic [2:0] m;
    m = 3'b111;
    for (int k = 0; k < (n == 0 ? 1 : n); k++) m = gen3(m) ^ 3'(k + 2);
    do_reset;
    sig_cycles = 8'(n);
    sig_expect = good ? m : ~m;
    mode = 2'b11; start = 1'b1; din = 3'(2);
    tick;
    start = 1'b0;
    check(done == 0, {tag, " done low after start"}, done, 0);
    for (int k = 1; k < (n == 0 ? 1 : n); k++) begin
      din = 3'(k + 2);
      tick;
      check(done == 0, {tag, " done low mid-run"}, done, 0);
    end
    din = 3'b000;
    tick;
    check(done == 1, {tag, " done at end"}, done, 1);
    check(pass == good, {tag, " pass value"}, pass, good);
    tick;
    check(done == 1 && pass == good, {tag, " flags hold"}, {done, pass}, {1'b1, good});
  endtask

  task automatic t_restart_and_reset;
    sig_run(2, 1, "R7 R8 short run");
    mode = 2'b11; start = 1'b1; sig_cycles = 8'd4;
    tick;
    start = 1'b0;
    check(done == 0 && pass == 0, "R7 start clears flags", {done, pass}, 0);
    sig_run(3, 1, "R8 pre-reset");
    rst = 1'b1;
    tick;
    rst = 1'b0;
    check(done == 0 && pass == 0 && q == 3'b111, "R1 reset mid-state", {done, pass, q}, 3'b111);
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_normal;
        t_scan;
        t_pattern;
        t_period8;
        t_signature;
        t_mode_switch;
        sig_run(5, 1, "R7 R8 match");
        sig_run(5, 0, "R8 mismatch");
        sig_run(0, 1, "R7 zero count");
        t_restart_and_reset;
      end
      begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule